// File: doc/BRIEF.md
# Self-Scrubbing Triplicated Register

This block is a register bank built to survive single-event upsets. Each logical bit is held in three flip-flops. A bitwise two-out-of-three vote over those copies drives the output. Every copy computes its next state from the voted value, never from its own content. With a clock that runs on every cycle, even while the data is only being held, any single flipped copy is overwritten by the majority at the next edge. This scrubbing removes an upset before a second one can land on another copy of the same bit.

The register has three operations: keep its value, take a parallel word, or shift one place toward the most significant bit with a serial bit entering at bit 0. The next-state multiplexer is repeated inside each copy, so no single selector is shared by all three. A fault-injection port can invert chosen bits in chosen copies on the next state, for one cycle only. A pulse output reports any disagreement between copies, and a sticky output keeps that report until reset.

All pins are plain control and status signals. The block moves no data stream, so it has no valid/ready handshake and never applies back-pressure: a new operation is accepted on every clock.

Top module: `tmr_scrub_reg`

## Requirements
- R1: A synchronous active-high `rst` clears all three copies of every bit. After a reset edge, `q` is 0 and both `mismatch` and `mismatch_sticky` are 0.
- R2: With `mode` = 2'b01, `q` equals `load_data` one clock later.
- R3: With `mode` = 2'b00 and no injection, `q` keeps its value across the clock edge.
- R4: With `mode` = 2'b10, after the edge `q` is the old `q` shifted one place toward the MSB, with `ser_in` placed in bit 0.
- R5: `mode` = 2'b11 is reserved and behaves exactly like hold.
- R6: With `inj_stb` high, each copy k whose bit `inj_sel[k]` is set takes its normal next state XOR `inj_mask` for that edge only. When exactly one copy is selected, `q` after the edge is the same as it would have been without the injection.
- R7: On a clock edge with `inj_stb` low, all three copies take the same voted next state, so any single-copy upset is gone one clock after it appears.
- R8: `mismatch` is high in exactly those cycles in which, for at least one bit, the three copies are not all equal.
- R9: `mismatch_sticky` goes high on the edge that follows any cycle with `mismatch` high, and stays high until reset.
- R10: When two copies of one bit are corrupted on the same edge, `q` follows the wrong majority. Scrubbing then copies that wrong value into the third copy, so the error is not corrected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock; it must also toggle while the register holds |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | 00 hold, 01 parallel load, 10 shift toward MSB, 11 hold |
| load_data | input | WIDTH | Word taken in parallel-load mode |
| ser_in | input | 1 | Bit entering bit 0 in shift mode |
| inj_stb | input | 1 | Fault-injection strobe, one cycle |
| inj_sel | input | 3 | Copy-select bits for injection; bit k targets copy k |
| inj_mask | input | WIDTH | Bits to invert in the selected copies |
| q | output | WIDTH | Bitwise majority of the three copies |
| mismatch | output | 1 | High while any bit's copies disagree |
| mismatch_sticky | output | 1 | Set by any mismatch, cleared only by reset |

## Verification
The bench injects single-copy faults in hold, shift and load modes. A design that fed each copy its own value back would keep the disagreement, so `mismatch` would stay high past one cycle. A design that used one copy instead of the vote would show the corruption on `q`. The bench also corrupts two copies of one bit on the same edge and expects the wrong value to persist. A voter with a wrong term, or a scrub that skipped the third copy, would show a different `q` or a `mismatch` that never clears. The reserved mode code, the sticky flag across several clean cycles, and a second reset that must clear the sticky flag are all checked.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int COPIES = 3;

  typedef enum logic [1:0] {
    MODE_HOLD  = 2'b00,
    MODE_LOAD  = 2'b01,
    MODE_SHIFT = 2'b10,
    MODE_RSVD  = 2'b11
  } mode_e;
endpackage

// File: rtl/tmr_voter.sv
module tmr_voter #(
  parameter int WIDTH = 8
) (
  input  logic [2:0][WIDTH-1:0] cp,
  output logic [WIDTH-1:0]      voted,
  output logic                  disagree
);
  logic [WIDTH-1:0] diff_bits;

  always_comb begin
    voted     = (cp[0] & cp[1]) | (cp[1] & cp[2]) | (cp[0] & cp[2]);
    diff_bits = (cp[0] ^ cp[1]) | (cp[1] ^ cp[2]);
    disagree  = |diff_bits;
  end
endmodule

// File: rtl/tmr_copy.sv
module tmr_copy
  import tmr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode,
  input  logic [WIDTH-1:0] voted,
  input  logic [WIDTH-1:0] load_data,
  input  logic             ser_in,
  input  logic             inj_en,
  input  logic [WIDTH-1:0] inj_mask,
  output logic [WIDTH-1:0] cq
);
  logic [WIDTH-1:0] shifted;
  logic [WIDTH-1:0] base_nxt;
  logic [WIDTH-1:0] flip;
  mode_e            m;

  generate
    if (WIDTH == 1) begin : g_narrow
      assign shifted = ser_in;
    end else begin : g_wide
      assign shifted = {voted[WIDTH-2:0], ser_in};
    end
  endgenerate

  always_comb begin
    m = mode_e'(mode);
    unique case (m)
      MODE_LOAD:  base_nxt = load_data;
      MODE_SHIFT: base_nxt = shifted;
      default:    base_nxt = voted;
    endcase
    flip = inj_en ? inj_mask : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) cq <= '0;
    else     cq <= base_nxt ^ flip;
  end
endmodule

// File: rtl/tmr_scrub_reg.sv
module tmr_scrub_reg
  import tmr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode,
  input  logic [WIDTH-1:0] load_data,
  input  logic             ser_in,
  input  logic             inj_stb,
  input  logic [2:0]       inj_sel,
  input  logic [WIDTH-1:0] inj_mask,
  output logic [WIDTH-1:0] q,
  output logic             mismatch,
  output logic             mismatch_sticky
);
  logic [2:0][WIDTH-1:0] copies;
  logic [WIDTH-1:0]      voted;
  logic                  disagree;

  tmr_voter #(.WIDTH(WIDTH)) u_voter (
    .cp       (copies),
    .voted    (voted),
    .disagree (disagree)
  );

  generate
    for (genvar k = 0; k < COPIES; k++) begin : g_copy
      tmr_copy #(.WIDTH(WIDTH)) u_copy (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .voted     (voted),
        .load_data (load_data),
        .ser_in    (ser_in),
        .inj_en    (inj_stb & inj_sel[k]),
        .inj_mask  (inj_mask),
        .cq        (copies[k])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)           mismatch_sticky <= 1'b0;
    else if (disagree) mismatch_sticky <= 1'b1;
  end

  assign q        = voted;
  assign mismatch = disagree;
endmodule

// File: rtl/tmr_scrub_reg_chk.sv
module tmr_scrub_reg_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       mode,
  input logic [WIDTH-1:0] load_data,
  input logic             ser_in,
  input logic             inj_stb,
  input logic [2:0]       inj_sel,
  input logic [WIDTH-1:0] q,
  input logic             mismatch,
  input logic             mismatch_sticky
);
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (q == '0 && !mismatch && !mismatch_sticky)); // R1

  AST_LOAD_TAKES_WORD: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b01 && !inj_stb) |=> q == $past(load_data)); // R2

  AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b00 && !inj_stb) |=> $stable(q)); // R3

  AST_RSVD_IS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b11 && !inj_stb) |=> $stable(q)); // R5

  AST_SINGLE_HIDDEN: assert property (@(posedge clk) disable iff (rst)
    (inj_stb && $countones(inj_sel) == 1 && mode == 2'b00) |=> $stable(q)); // R6

  AST_SCRUB_CLEARS: assert property (@(posedge clk) disable iff (rst)
    !inj_stb |=> !mismatch); // R7

  AST_STICKY_SETS: assert property (@(posedge clk) disable iff (rst)
    mismatch |=> mismatch_sticky); // R9

  AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (rst)
    mismatch_sticky |=> mismatch_sticky); // R9

  generate
    if (WIDTH > 1) begin : g_shift_chk
      AST_SHIFT_MOVES: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b10 && !inj_stb) |=>
          q == {$past(q[WIDTH-2:0]), $past(ser_in)}); // R4
    end
  endgenerate
endmodule

bind tmr_scrub_reg tmr_scrub_reg_chk #(.WIDTH(WIDTH)) u_chk (
  .clk             (clk),
  .rst             (rst),
  .mode            (mode),
  .load_data       (load_data),
  .ser_in          (ser_in),
  .inj_stb         (inj_stb),
  .inj_sel         (inj_sel),
  .q               (q),
  .mismatch        (mismatch),
  .mismatch_sticky (mismatch_sticky)
);

// File: tb/tb_tmr_scrub_reg.sv
module tb_tmr_scrub_reg;
  localparam int W = 8;
  localparam time CLK_PERIOD = 10ns;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [1:0]   mode = 2'b00;
  logic [W-1:0] load_data = '0;
  logic         ser_in = 1'b0;
  logic         inj_stb = 1'b0;
  logic [2:0]   inj_sel = '0;
  logic [W-1:0] inj_mask = '0;
  logic [W-1:0] q;
  logic         mismatch;
  logic         mismatch_sticky;

  tmr_scrub_reg #(.WIDTH(W)) dut (
    .clk(clk), .rst(rst), .mode(mode), .load_data(load_data), .ser_in(ser_in),
    .inj_stb(inj_stb), .inj_sel(inj_sel), .inj_mask(inj_mask),
    .q(q), .mismatch(mismatch), .mismatch_sticky(mismatch_sticky)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [W-1:0] q;
    logic         mm;
    logic         st;
    string        req;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk  = 0;
  int   n_fail = 0;
  bit   done   = 1'b0;

  // Expected state from the requirements: three copies, voted output.
  logic [W-1:0] m0 = '0, m1 = '0, m2 = '0;
  logic         m_st = 1'b0;

  function automatic logic [W-1:0] maj(logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] c);
    return (a & b) | (b & c) | (a & c);
  endfunction

  task automatic cyc(input logic r, input logic [1:0] md, input logic [W-1:0] ld,
                     input logic si, input logic [2:0] sel, input logic [W-1:0] msk,
                     input string req);
    logic [W-1:0] v, nb;
    exp_t e;
    rst = r; mode = md; load_data = ld; ser_in = si;
    inj_stb = (sel != 3'b000); inj_sel = sel; inj_mask = msk;
    @(posedge clk);
    #1;
    v = maj(m0, m1, m2);
    case (md)
      2'b01:   nb = ld;
      2'b10:   nb = {v[W-2:0], si};
      default: nb = v;
    endcase
    if (r) begin
      m0 = '0; m1 = '0; m2 = '0; m_st = 1'b0;
    end else begin
      if ((m0 != m1) || (m1 != m2)) m_st = 1'b1;
      m0 = nb ^ (sel[0] ? msk : '0);
      m1 = nb ^ (sel[1] ? msk : '0);
      m2 = nb ^ (sel[2] ? msk : '0);
    end
    e.q = maj(m0, m1, m2);
    e.mm = (m0 != m1) || (m1 != m2);
    e.st = m_st;
    e.req = req;
    exp_q.push_back(e);
  endtask

  // Monitor: compare each expected item away from the active edge.
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        n_chk++;
        if (q !== e.q || mismatch !== e.mm || mismatch_sticky !== e.st) begin
          n_fail++;
          $display("FAIL %s: q=%h mismatch=%b sticky=%b expected q=%h mismatch=%b sticky=%b",
                   e.req, q, mismatch, mismatch_sticky, e.q, e.mm, e.st);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    cyc(1, 2'b00, '0, 0, 3'b000, '0, "R1");
    cyc(1, 2'b00, '0, 0, 3'b000, '0, "R1");
    // R2: load
    cyc(0, 2'b01, 8'hA5, 0, 3'b000, '0, "R2");
    // R3: hold
    cyc(0, 2'b00, 8'hFF, 1, 3'b000, '0, "R3");
    cyc(0, 2'b00, 8'h00, 0, 3'b000, '0, "R3");
    // R5: reserved code holds
    cyc(0, 2'b11, 8'h5A, 1, 3'b000, '0, "R5");
    // R4: shift toward MSB, serial into bit 0
    cyc(0, 2'b10, '0, 1, 3'b000, '0, "R4");
    cyc(0, 2'b10, '0, 0, 3'b000, '0, "R4");
    cyc(0, 2'b10, '0, 1, 3'b000, '0, "R4");
    cyc(0, 2'b01, 8'h3C, 0, 3'b000, '0, "R2");
    // R6/R8: single-copy injection in hold, output untouched, mismatch raised
    cyc(0, 2'b00, '0, 0, 3'b001, 8'h81, "R6 R8");
    // R7/R9: scrubbed one clock later, sticky set
    cyc(0, 2'b00, '0, 0, 3'b000, '0, "R7 R9");
    cyc(0, 2'b00, '0, 0, 3'b000, '0, "R9");
    // R6: injection into copy 2 while shifting
    cyc(0, 2'b10, '0, 1, 3'b100, 8'hF0, "R6");
    cyc(0, 2'b00, '0, 0, 3'b000, '0, "R7");
    // R6: injection into copy 1 while loading
    cyc(0, 2'b01, 8'h96, 0, 3'b010, 8'hFF, "R6");
    cyc(0, 2'b11, '0, 0, 3'b000, '0, "R7");
    // R10: two copies of bit 4 corrupted on one edge
    cyc(0, 2'b00, '0, 0, 3'b011, 8'h10, "R10");
    cyc(0, 2'b00, '0, 0, 3'b000, '0, "R10");
    cyc(0, 2'b00, '0, 0, 3'b000, '0, "R10");
    // R1/R9: second reset clears the sticky flag
    cyc(1, 2'b00, '0, 0, 3'b000, '0, "R1 R9");
    cyc(0, 2'b00, '0, 0, 3'b000, '0, "R3");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule